// File: doc/BRIEF.md
# Shift-Offset Sum and Square Execution Unit

This block is an integer execution unit for a machine with eight general registers. It is placed in the multiply-class opcode slot, and it also carries register addition there. It takes the current value of the destination register, two source register values, a short signed immediate and a coarse left-shift select. It then produces one of two results:

- an offset sum, in which the immediate is added to the second source, the total is shifted left and the first source is added;
- the square of the first source.

Either form can also add the old destination value into the result. Every sum and product keeps only its low data word. The unit flags no overflow and offers no divide.

The unit has two register stages. In the first stage the shifted sum or the square is formed. The second stage adds the optional accumulate and holds the registered result. A valid bit and the destination register index travel with each operation. A write-enable tells the register file whether the result should be written back. The data width, immediate width, shift-select width, shift step and squarer structure are all parameters.

Top module: `pmadd_unit`

## Requirements
- R1: With `in_op` = 0 the result is `in_src_b + ((sext(in_imm) + in_src_c) << (8*in_pre))`.
- R2: With `in_op` = 1 the result is `in_dst_val + in_src_b + ((sext(in_imm) + in_src_c) << (8*in_pre))`.
- R3: With `in_op` = 2 the result is the low 32 bits of the signed product `in_src_b * in_src_b`, for any input value.
- R4: With `in_op` = 3 the result is `in_dst_val` plus the low 32 bits of `in_src_b * in_src_b`.
- R5: The 2-bit `in_pre` field selects a left shift of 0, 8, 16 or 24 bits. Bits shifted above bit 31 are dropped.
- R6: `in_imm` is a 4-bit two's complement value that is sign-extended to 32 bits (range -8 to +7). An immediate of 0 with `in_pre` = 0 gives a plain `in_src_b + in_src_c`.
- R7: Every sum and product wraps modulo 2^32, and no overflow indication exists.
- R8: An operation accepted with `in_valid` high at rising edge N shows `out_valid` high, together with its result, after rising edge N+1. The output is low before that edge.
- R9: Op codes 4 to 7 are unused. They still produce `out_valid`, but `out_we` stays low. Op codes 0 to 3 produce `out_we` high.
- R10: While `rst_n` is low, `out_valid`, `out_we` and `out_result` are all 0.
- R11: `out_dst_idx` equals the `in_dst_idx` that was given with the operation now on the output.
- R12: `out_result` holds its last value while no valid operation reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation select (0 sum, 1 accumulate sum, 2 square, 3 accumulate square) |
| in_dst_idx | input | 3 | Destination register index |
| in_dst_val | input | 32 | Current destination register value |
| in_src_b | input | 32 | First source register value |
| in_src_c | input | 32 | Second source register value |
| in_imm | input | 4 | Signed immediate added to the second source |
| in_pre | input | 2 | Left-shift select, step of 8 bits |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Write the result back |
| out_dst_idx | output | 3 | Destination register index of the result |
| out_result | output | 32 | Result value |

## Verification
The bench sweeps every op code, every shift select and every immediate value over pseudo-random register values. It then targets these corner cases:

- **Negative immediates.** A unit that zero-extends the immediate would produce results that are off by 16 times the shift weight.
- **The top shift select.** A unit that lets shifted bits leak or keeps too few of them gets the top byte wrong.
- **Squares of the most negative value and of small negative values.** A squarer that treats the input as unsigned would still give the right low word, but one that mangles the sign would not.
- **Sums that cross 2^32.** A unit that saturates or widens its result would differ from the wrapped value.

Directed runs also check the two-edge latency, the suppressed write-enable for unused op codes and that the result is held during bubbles. A unit that drops an operation or mixes up destination indices then shows up as a mismatched index or result.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OPC_SUM     = 3'd0,
      OPC_SUM_ACC = 3'd1,
      OPC_SQR     = 3'd2,
      OPC_SQR_ACC = 3'd3
   } opc_e;

   // Only the lower half of the op-code space is defined.
   function automatic logic opc_defined(input logic [OP_W-1:0] op);
      return (op[OP_W-1] == 1'b0);
   endfunction

   // Bit 0 of a defined op code selects accumulate.
   function automatic logic opc_accumulates(input logic [OP_W-1:0] op);
      return op[0];
   endfunction

   // Bit 1 of a defined op code selects the square form.
   function automatic logic opc_squares(input logic [OP_W-1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/pmadd_sum.sv
module pmadd_sum #(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 4,
   parameter int PRE_W      = 2,
   parameter int SHIFT_STEP = 8
) (
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] src_c,
   input  logic [IMM_W-1:0]  imm,
   input  logic [PRE_W-1:0]  pre,
   output logic [DATA_W-1:0] sum
);
   localparam int MAX_SHIFT = SHIFT_STEP * ((1 << PRE_W) - 1);
   localparam int SH_W      = $clog2(MAX_SHIFT + 1) + 1;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] offset;
   logic [SH_W-1:0]   sh_amt;

   assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
   assign offset  = imm_ext + src_c;
   assign sh_amt  = SH_W'(pre) * SH_W'(SHIFT_STEP);
   assign sum     = src_b + (offset << sh_amt);

endmodule

// File: rtl/pmadd_square.sv
module pmadd_square #(
   parameter int DATA_W  = 32,
   parameter int SQ_IMPL = 0
) (
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] sq
);
   // The low word of a product is the same for signed and unsigned operands.
   generate
      if (SQ_IMPL == 0) begin : g_operator
         assign sq = src * src;
      end else begin : g_shift_add
         logic [DATA_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (src[i]) acc = acc + (src << i);
            end
         end
         assign sq = acc;
      end
   endgenerate

endmodule

// File: rtl/pmadd_acc_stage.sv
module pmadd_acc_stage #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic              s1_we,
   input  logic              s1_acc,
   input  logic [IDX_W-1:0]  s1_idx,
   input  logic [DATA_W-1:0] s1_dst,
   input  logic [DATA_W-1:0] s1_part,
   output logic              out_valid,
   output logic              out_we,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_result
);
   logic [DATA_W-1:0] addend;
   logic [DATA_W-1:0] total;

   assign addend = s1_acc ? s1_dst : '0;
   assign total  = addend + s1_part;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_we     <= 1'b0;
         out_idx    <= '0;
         out_result <= '0;
      end else begin
         out_valid <= s1_valid;
         out_we    <= s1_valid & s1_we;
         if (s1_valid) begin
            out_idx    <= s1_idx;
            out_result <= total;
         end
      end
   end

endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit
   import pmadd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 4,
   parameter int PRE_W      = 2,
   parameter int SHIFT_STEP = 8,
   parameter int IDX_W      = 3,
   parameter int SQ_IMPL    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_op,
   input  logic [IDX_W-1:0]  in_dst_idx,
   input  logic [DATA_W-1:0] in_dst_val,
   input  logic [DATA_W-1:0] in_src_b,
   input  logic [DATA_W-1:0] in_src_c,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic [PRE_W-1:0]  in_pre,
   output logic              out_valid,
   output logic              out_we,
   output logic [IDX_W-1:0]  out_dst_idx,
   output logic [DATA_W-1:0] out_result
);
   localparam int MAX_SHIFT = SHIFT_STEP * ((1 << PRE_W) - 1);

   // Elaboration-time parameter checks
   if (MAX_SHIFT >= DATA_W) begin : g_bad_shift
      $error("pmadd_unit: largest shift must stay below DATA_W");
   end
   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
      $error("pmadd_unit: IMM_W must lie in 1..DATA_W");
   end
   if (SQ_IMPL != 0 && SQ_IMPL != 1) begin : g_bad_sq
      $error("pmadd_unit: SQ_IMPL must be 0 or 1");
   end

   logic [DATA_W-1:0] sum_val;
   logic [DATA_W-1:0] sq_val;
   logic [DATA_W-1:0] part_d;

   pmadd_sum #(
      .DATA_W(DATA_W), .IMM_W(IMM_W), .PRE_W(PRE_W), .SHIFT_STEP(SHIFT_STEP)
   ) u_sum (
      .src_b(in_src_b), .src_c(in_src_c), .imm(in_imm), .pre(in_pre), .sum(sum_val)
   );

   pmadd_square #(.DATA_W(DATA_W), .SQ_IMPL(SQ_IMPL)) u_sq (
      .src(in_src_b), .sq(sq_val)
   );

   assign part_d = opc_squares(in_op) ? sq_val : sum_val;

   // Stage 1: the multiply/add result is registered
   logic              s1_valid;
   logic              s1_we;
   logic              s1_acc;
   logic [IDX_W-1:0]  s1_idx;
   logic [DATA_W-1:0] s1_dst;
   logic [DATA_W-1:0] s1_part;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_we    <= 1'b0;
         s1_acc   <= 1'b0;
         s1_idx   <= '0;
         s1_dst   <= '0;
         s1_part  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_we   <= opc_defined(in_op);
            s1_acc  <= opc_accumulates(in_op);
            s1_idx  <= in_dst_idx;
            s1_dst  <= in_dst_val;
            s1_part <= part_d;
         end
      end
   end

   // Stage 2: accumulate and result register
   pmadd_acc_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .s1_valid(s1_valid), .s1_we(s1_we), .s1_acc(s1_acc),
      .s1_idx(s1_idx), .s1_dst(s1_dst), .s1_part(s1_part),
      .out_valid(out_valid), .out_we(out_we),
      .out_idx(out_dst_idx), .out_result(out_result)
   );

endmodule

// File: rtl/pmadd_chk.sv
module pmadd_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 4,
   parameter int PRE_W  = 2,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        in_op,
   input logic [IDX_W-1:0]  in_dst_idx,
   input logic [DATA_W-1:0] in_src_b,
   input logic [DATA_W-1:0] in_src_c,
   input logic [IMM_W-1:0]  in_imm,
   input logic [PRE_W-1:0]  in_pre,
   input logic              out_valid,
   input logic              out_we,
   input logic [IDX_W-1:0]  out_dst_idx,
   input logic [DATA_W-1:0] out_result
);
   logic [1:0]        warm;
   logic              wr_in;
   logic              sq_in;
   logic              plain_in;
   logic [DATA_W-1:0] sq_now;
   logic [DATA_W-1:0] bc_now;

   always_ff @(posedge clk) begin
      if (!rst_n) warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   assign wr_in    = in_valid && (in_op[2] == 1'b0);
   assign sq_in    = in_valid && (in_op == 3'd2);
   assign plain_in = in_valid && (in_op == 3'd0) && (in_imm == '0) && (in_pre == '0);
   assign sq_now   = in_src_b * in_src_b;
   assign bc_now   = in_src_b + in_src_c;

   // R9
   we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |-> out_valid);

   // R8
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R9
   we_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2) |-> (out_we == $past(wr_in, 2)));

   // R11
   idx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(in_valid, 2)) |-> (out_dst_idx == $past(in_dst_idx, 2)));

   // R3
   square_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(sq_in, 2)) |-> (out_result == $past(sq_now, 2)));

   // R6
   plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && $past(plain_in, 2)) |-> (out_result == $past(bc_now, 2)));

   // R12
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && !out_valid) |-> $stable(out_result));

endmodule

bind pmadd_unit pmadd_chk #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .PRE_W(PRE_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .in_dst_idx(in_dst_idx), .in_src_b(in_src_b), .in_src_c(in_src_c),
   .in_imm(in_imm), .in_pre(in_pre), .out_valid(out_valid), .out_we(out_we),
   .out_dst_idx(out_dst_idx), .out_result(out_result)
);

// File: tb/pmadd_unit_tb.sv
module pmadd_unit_tb;
   localparam int CLK_P = 10;
   localparam int SB_N  = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [2:0]  in_dst_idx = '0;
   logic [31:0] in_dst_val = '0;
   logic [31:0] in_src_b = '0;
   logic [31:0] in_src_c = '0;
   logic [3:0]  in_imm = '0;
   logic [1:0]  in_pre = '0;
   logic        out_valid;
   logic        out_we;
   logic [2:0]  out_dst_idx;
   logic [31:0] out_result;

   int total = 0;
   int bad   = 0;
   logic [31:0] lcg = 32'h1234_5678;

   logic [31:0] exp_res [SB_N];
   logic        exp_we  [SB_N];
   logic [2:0]  exp_idx [SB_N];
   string       exp_tag [SB_N];
   int wr = 0;
   int rd = 0;

   always #(CLK_P/2) clk = ~clk;

   pmadd_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dst_idx(in_dst_idx), .in_dst_val(in_dst_val), .in_src_b(in_src_b),
      .in_src_c(in_src_c), .in_imm(in_imm), .in_pre(in_pre),
      .out_valid(out_valid), .out_we(out_we), .out_dst_idx(out_dst_idx),
      .out_result(out_result)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   // Expected value straight from the requirement formulas
   function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] d,
         input logic [31:0] b, input logic [31:0] c, input logic [3:0] imm,
         input logic [1:0] pre);
      longint sb;
      longint sqw;
      logic [31:0] off;
      logic [31:0] shv;
      off = 32'($signed(imm)) + c;
      shv = off << (8 * int'(pre));
      sb  = longint'($signed(b));
      sqw = sb * sb;
      case (op)
         3'd0:    return b + shv;
         3'd1:    return d + b + shv;
         3'd2:    return sqw[31:0];
         3'd3:    return d + sqw[31:0];
         default: return 32'h0;
      endcase
   endfunction

   // Compare the outputs at the negative edge, then drive the next input
   task automatic step(input bit v, input logic [2:0] op, input logic [2:0] idx,
                       input logic [31:0] d, input logic [31:0] b, input logic [31:0] c,
                       input logic [3:0] imm, input logic [1:0] pre, input string tag);
      @(negedge clk);
      if (out_valid) begin
         if (rd == wr) begin
            chk(1'b0, "R8 unexpected out_valid", {31'b0, out_valid}, 32'h0);
         end else begin
            if (exp_we[rd])
               chk(out_result == exp_res[rd], exp_tag[rd], out_result, exp_res[rd]);
            chk(out_we == exp_we[rd], "R9 write enable", {31'b0, out_we},
                {31'b0, exp_we[rd]});
            chk(out_dst_idx == exp_idx[rd], "R11 dest index", {29'b0, out_dst_idx},
                {29'b0, exp_idx[rd]});
            rd++;
         end
      end
      in_valid = v; in_op = op; in_dst_idx = idx; in_dst_val = d;
      in_src_b = b; in_src_c = c; in_imm = imm; in_pre = pre;
      if (v) begin
         exp_res[wr] = model(op, d, b, c, imm, pre);
         exp_we[wr]  = (op[2] == 1'b0);
         exp_idx[wr] = idx;
         exp_tag[wr] = tag;
         wr++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 3'd0, 0, 0, 0, 4'd0, 2'd0, "");
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] held;
      string tg;
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid in reset", {31'b0, out_valid}, 32'h0);
      chk(out_we == 1'b0, "R10 out_we in reset", {31'b0, out_we}, 32'h0);
      chk(out_result == 32'h0, "R10 out_result in reset", out_result, 32'h0);
      rst_n = 1'b1;

      // Sweep every op code, shift select and immediate (R1 R2 R3 R4 R5 R9)
      for (int op = 0; op < 8; op++) begin
         for (int pre = 0; pre < 4; pre++) begin
            for (int imm = 0; imm < 16; imm++) begin
               case (op)
                  0: tg = (pre != 0) ? "R5 shifted sum" : "R1 sum";
                  1: tg = (pre != 0) ? "R5 shifted acc sum" : "R2 acc sum";
                  2: tg = "R3 square";
                  3: tg = "R4 acc square";
                  default: tg = "R9 unused op";
               endcase
               step(1'b1, 3'(op), 3'(imm), next_rand(), next_rand(), next_rand(),
                    4'(imm), 2'(pre), tg);
            end
         end
      end

      // Directed corner cases
      step(1'b1, 3'd0, 3'd1, 32'h0, 32'd5, 32'd7, 4'd0, 2'd0, "R6 zero imm plain add");
      step(1'b1, 3'd0, 3'd2, 32'h0, 32'd100, 32'd0, 4'hF, 2'd0, "R6 imm minus one");
      step(1'b1, 3'd0, 3'd3, 32'h0, 32'd0, 32'd0, 4'h8, 2'd3, "R6 imm minus eight top shift");
      step(1'b1, 3'd0, 3'd4, 32'h0, 32'hFFFF_FFFF, 32'd2, 4'd0, 2'd0, "R7 sum wrap");
      step(1'b1, 3'd1, 3'd5, 32'h8000_0000, 32'h8000_0000, 32'd0, 4'd0, 2'd0, "R7 acc wrap");
      step(1'b1, 3'd2, 3'd6, 32'h0, 32'h8000_0000, 32'd0, 4'd0, 2'd0, "R3 square min neg");
      step(1'b1, 3'd2, 3'd7, 32'h0, 32'hFFFF_FFFD, 32'd0, 4'd0, 2'd0, "R3 square minus three");
      step(1'b1, 3'd2, 3'd0, 32'h0, 32'h0001_0000, 32'd0, 4'd0, 2'd0, "R7 square wrap");
      step(1'b1, 3'd3, 3'd1, 32'd10, 32'hFFFF_FFFF, 32'd0, 4'd0, 2'd0, "R4 acc square neg");
      step(1'b1, 3'd0, 3'd2, 32'h0, 32'd0, 32'h0000_0101, 4'd0, 2'd3, "R5 bits above 31 dropped");
      step(1'b1, 3'd5, 3'd3, 32'h0, 32'd1, 32'd1, 4'd0, 2'd0, "R9 unused op five");
      idle(4);
      chk(rd == wr, "R8 every operation returned", 32'(rd), 32'(wr));

      // R12 result held through bubbles
      held = out_result;
      idle(3);
      chk(out_result == held, "R12 result held", out_result, held);

      // R8 exact latency, driven by hand
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'd0; in_dst_idx = 3'd6; in_dst_val = 0;
      in_src_b = 32'd40; in_src_c = 32'd2; in_imm = 4'd0; in_pre = 2'd0;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R8 not yet valid after one edge", {31'b0, out_valid}, 32'h0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid after two edges", {31'b0, out_valid}, 32'h1);
      chk(out_result == 32'd42, "R8 result at latency", out_result, 32'd42);
      chk(out_dst_idx == 3'd6, "R11 index at latency", {29'b0, out_dst_idx}, 32'd6);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 single valid pulse", {31'b0, out_valid}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule